// File: doc/BRIEF.md
# Battery Charge Cycle Controller

This block is the phase sequencer of a fast charger for nickel-based cells. Analog comparators outside the block turn cell voltage and pack temperature into single-bit flags, and a separate measurement path raises one flag when a slope or peak test ends fast charge. From these flags the controller walks each charge cycle through its phases. The optional phases are a discharge done before charging and a reduced-rate top-off. Between them come a qualification wait, fast charge, and maintenance trickle. Two end states cover a full battery and a removed battery. The block drives the discharge switch, a 2-bit phase code for the current modulator, and two LED outputs.

The block holds the safety timer that limits fast charge and top-off. It also holds the window timer that tells a full pack (cell voltage drops back) from a removed one (cell voltage stays above the maximum). Three-valued configuration pins are presented as 2-bit codes: 00 is low, 01 is floating, and 10 or 11 is high. All time bases are parameters, so a bench can scale seconds and minutes down to a few clocks.

Top module: `chg_cycle_ctrl`

## Requirements
- R1: While `supply_ok_i` is low, `inhibit_n_i` is low or reset is asserted, the block is idle from the next clock edge: `out_en_o`=0, `dis_o`=0, `phase_o`=00, both LEDs 0.
- R2: When supply and inhibit are both high in the idle state, the next edge starts a new cycle. It enters discharge if `dis_cmd_n_i` is low at that moment and qualification otherwise.
- R3: A high-to-low edge on `dis_cmd_n_i` in any active state enters discharge on that edge. During discharge `dis_o`=1 and `phase_o`=00. Discharge ends when `cell_under_edv_i` is high, and the block then moves to qualification.
- R4: In qualification, fast charge is entered on the next edge when the cell is neither over the maximum nor under end-of-discharge, `temp_hot_i` is low, and either `temp_cold_i` is low or `vterm_mode_i` selects peak mode (high code). Otherwise the block waits with no time limit.
- R5: The cell over its maximum during qualification leads to battery-absent. Battery-absent is left only when `cell_over_max_i` falls, which starts a new cycle as in R2.
- R6: When the cell goes over its maximum in fast charge, top-off or complete, `phase_o`=00 and both LEDs are 0 from the next edge. If the flag clears within MCV_EIGHTHS eighth-seconds the block moves to complete. If it is still set after that, the block moves to battery-absent.
- R7: Fast charge ends on `term_slope_i`, on `temp_cut_i`, on `temp_cold_i` (except in peak mode) or on safety time-out. It goes to top-off when the rate code enables top-off and to complete otherwise.
- R8: The safety timer restarts for top-off. Its limit comes from the two rate codes `{rate_b,rate_a}` in levels L/F/H: LL 360, LF 180, LH 90, FL 45, FF 23 minutes with no top-off; FH 180, HL 90, HF 45, HH 23 minutes with top-off. Top-off ends only on time-out, `temp_cut_i` or the cell over its maximum. The slope and cold flags are ignored there.
- R9: `phase_o` is 00 off, 01 fast, 10 top-off and 11 trickle. Qualification and complete use trickle.
- R10: `{led1_o,led2_o}` depends on the display mode. In low-code mode: absent 00, qualification or discharge 11, fast 01, top-off or complete 10. In floating-code mode: qualification 10, discharge 01, top-off 11, every other state 00.
- R11: In high-code display mode, qualification and discharge show `led1_o`=0 and `led2_o` toggling every eighth-second (EIGHTH_DIV clocks). Fast shows 01, and top-off or complete shows 10.
- R12: With both rate codes low, trickle is disabled: qualification and complete show `phase_o`=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply within range |
| inhibit_n_i | input | 1 | Low suspends all charge activity |
| dis_cmd_n_i | input | 1 | Discharge request, active low |
| cell_over_max_i | input | 1 | Cell voltage above maximum |
| cell_under_edv_i | input | 1 | Cell voltage below end-of-discharge |
| temp_cut_i | input | 1 | Temperature past the cutoff (too hot to charge) |
| temp_cold_i | input | 1 | Temperature past the low-fault limit |
| temp_hot_i | input | 1 | Temperature past the high-fault limit |
| term_slope_i | input | 1 | Slope or voltage-drop termination seen |
| rate_a_i | input | 2 | First rate configuration code |
| rate_b_i | input | 2 | Second rate configuration code |
| disp_mode_i | input | 2 | LED display mode code |
| vterm_mode_i | input | 2 | Voltage termination mode code (high = peak mode) |
| out_en_o | output | 1 | Outputs driven (low when idle) |
| dis_o | output | 1 | Discharge switch control |
| phase_o | output | 2 | Modulator phase code |
| led1_o | output | 1 | Status LED 1 |
| led2_o | output | 1 | Status LED 2 |

## Verification
All outputs are decoded from the registered state, so a flag change applied before an edge shows up in every output right after that same edge. The bench changes inputs on the falling clock edge and reads the outputs on the following falling edge. The two timers are checked with a margin, not at a single cycle. With the scaled bench parameters, safety expiry is due 185 edges after fast-charge or top-off entry, and the maximum-voltage window closes 13 edges after it opens. Each timer is probed well before and well after its due edge. The blink is checked by counting toggles of `led2_o` over 40 clocks.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ABSENT, ST_DISCH, ST_PEND,
    ST_FAST, ST_TOPOFF, ST_DONE, ST_MCVW
  } chg_state_e;

  typedef enum logic [1:0] {
    PH_OFF = 2'd0, PH_FAST = 2'd1, PH_TOPOFF = 2'd2, PH_TRICKLE = 2'd3
  } chg_phase_e;

  typedef struct packed {
    logic [8:0] minutes;
    logic       topoff_en;
    logic       trickle_en;
  } chg_rate_t;

  // 0 = low, 1 = floating, 2 = high
  function automatic logic [1:0] tri_lvl(input logic [1:0] code);
    return code[1] ? 2'd2 : (code[0] ? 2'd1 : 2'd0);
  endfunction

  function automatic chg_rate_t decode_rate(input logic [1:0] ca, input logic [1:0] cb);
    chg_rate_t r;
    logic [1:0] a;
    logic [1:0] b;
    a = tri_lvl(ca);
    b = tri_lvl(cb);
    r.trickle_en = !(a == 2'd0 && b == 2'd0);
    r.topoff_en  = (b == 2'd2) || (b == 2'd1 && a == 2'd2);
    case ({b, a})
      4'h0:    r.minutes = 9'd360;
      4'h1:    r.minutes = 9'd180;
      4'h2:    r.minutes = 9'd90;
      4'h4:    r.minutes = 9'd45;
      4'h5:    r.minutes = 9'd23;
      4'h6:    r.minutes = 9'd180;
      4'h8:    r.minutes = 9'd90;
      4'h9:    r.minutes = 9'd45;
      4'hA:    r.minutes = 9'd23;
      default: r.minutes = 9'd360;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/chg_span_timer.sv
module chg_span_timer #(
  parameter int unsigned PRE_CLKS = 8,
  parameter int unsigned CNT_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  localparam int unsigned PRE_W = (PRE_CLKS > 1) ? $clog2(PRE_CLKS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_CLKS - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign done_o = (cnt_q >= limit_i);

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (run_i && !done_o) begin
      if (pre_q == PRE_LAST) begin
        pre_d = '0;
        cnt_d = cnt_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !clr_i) |=> done_o);

  // R8
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_q <= limit_i));

endmodule

// File: rtl/chg_blink_gen.sv
module chg_blink_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic blink_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          blink_q, blink_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    blink_d = wrap ? !blink_q : blink_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      blink_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      blink_q <= blink_d;
    end
  end

  assign blink_o = blink_q;

  // R11
  blink_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blink_q) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/chg_led_enc.sv
module chg_led_enc
  import chg_pkg::*;
(
  input  chg_state_e state_i,
  input  logic [1:0] mode_i,
  input  logic       blink_i,
  output logic [1:0] led_o
);
  logic [1:0] lvl;
  assign lvl = tri_lvl(mode_i);

  always_comb begin
    led_o = 2'b00;
    case (lvl)
      2'd0: begin
        case (state_i)
          ST_PEND, ST_DISCH:  led_o = 2'b11;
          ST_FAST:            led_o = 2'b01;
          ST_TOPOFF, ST_DONE: led_o = 2'b10;
          default:            led_o = 2'b00;
        endcase
      end
      2'd1: begin
        case (state_i)
          ST_PEND:   led_o = 2'b10;
          ST_DISCH:  led_o = 2'b01;
          ST_TOPOFF: led_o = 2'b11;
          default:   led_o = 2'b00;
        endcase
      end
      default: begin
        case (state_i)
          ST_PEND, ST_DISCH:  led_o = {1'b0, blink_i};
          ST_FAST:            led_o = 2'b01;
          ST_TOPOFF, ST_DONE: led_o = 2'b10;
          default:            led_o = 2'b00;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/chg_cycle_ctrl.sv
module chg_cycle_ctrl
  import chg_pkg::*;
#(
  parameter int unsigned EIGHTH_DIV  = 1000000,
  parameter int unsigned MIN_EIGHTHS = 480,
  parameter int unsigned MCV_EIGHTHS = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok_i,
  input  logic       inhibit_n_i,
  input  logic       dis_cmd_n_i,
  input  logic       cell_over_max_i,
  input  logic       cell_under_edv_i,
  input  logic       temp_cut_i,
  input  logic       temp_cold_i,
  input  logic       temp_hot_i,
  input  logic       term_slope_i,
  input  logic [1:0] rate_a_i,
  input  logic [1:0] rate_b_i,
  input  logic [1:0] disp_mode_i,
  input  logic [1:0] vterm_mode_i,
  output logic       out_en_o,
  output logic       dis_o,
  output logic [1:0] phase_o,
  output logic       led1_o,
  output logic       led2_o
);
  localparam int unsigned MIN_CLKS = EIGHTH_DIV * MIN_EIGHTHS;
  localparam int unsigned MCV_W    = $clog2(MCV_EIGHTHS + 1);
  localparam int unsigned SAFE_W   = 9;

  chg_state_e st_q, st_d, start_st;
  logic       dcmd_q, cmax_q;
  logic       dcmd_fall, active, peak_mode, qualified, fast_term;
  logic       safe_done, safe_clr, safe_run;
  logic       mcv_done, mcv_clr, mcv_run;
  logic       blink;
  logic [1:0] led;
  chg_rate_t  rate;

  assign rate      = decode_rate(rate_a_i, rate_b_i);
  assign active    = supply_ok_i && inhibit_n_i;
  assign dcmd_fall = dcmd_q && !dis_cmd_n_i;
  assign peak_mode = (vterm_mode_i == 2'b10) || (vterm_mode_i == 2'b11);
  assign start_st  = dis_cmd_n_i ? ST_PEND : ST_DISCH;
  assign qualified = !cell_under_edv_i && !temp_hot_i && (!temp_cold_i || peak_mode);
  assign fast_term = term_slope_i || temp_cut_i || (temp_cold_i && !peak_mode) || safe_done;

  // next-state logic
  always_comb begin
    st_d = st_q;
    if (!active) begin
      st_d = ST_IDLE;
    end else if (st_q == ST_IDLE) begin
      st_d = start_st;
    end else if (dcmd_fall) begin
      st_d = ST_DISCH;
    end else begin
      case (st_q)
        ST_ABSENT: if (cmax_q && !cell_over_max_i) st_d = start_st;
        ST_DISCH:  if (cell_under_edv_i) st_d = ST_PEND;
        ST_PEND: begin
          if (cell_over_max_i)  st_d = ST_ABSENT;
          else if (qualified)   st_d = ST_FAST;
        end
        ST_FAST: begin
          if (cell_over_max_i)  st_d = ST_MCVW;
          else if (fast_term)   st_d = rate.topoff_en ? ST_TOPOFF : ST_DONE;
        end
        ST_TOPOFF: begin
          if (cell_over_max_i)               st_d = ST_MCVW;
          else if (temp_cut_i || safe_done)  st_d = ST_DONE;
        end
        ST_DONE: if (cell_over_max_i) st_d = ST_MCVW;
        ST_MCVW: begin
          if (!cell_over_max_i) st_d = ST_DONE;
          else if (mcv_done)    st_d = ST_ABSENT;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dcmd_q <= 1'b1;
      cmax_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      dcmd_q <= dis_cmd_n_i;
      cmax_q <= cell_over_max_i;
    end
  end

  // safety timer: restarted on every entry into fast charge and into top-off
  assign safe_run = (st_q == ST_FAST) || (st_q == ST_TOPOFF);
  assign safe_clr = !safe_run || (st_q == ST_FAST && st_d == ST_TOPOFF);

  chg_span_timer #(.PRE_CLKS(MIN_CLKS), .CNT_W(SAFE_W)) safe_tmr_i (
    .clk(clk), .rst_n(rst_n), .clr_i(safe_clr), .run_i(safe_run),
    .limit_i(rate.minutes), .done_o(safe_done)
  );

  // maximum-voltage window timer
  assign mcv_run = (st_q == ST_MCVW);
  assign mcv_clr = !mcv_run;

  chg_span_timer #(.PRE_CLKS(EIGHTH_DIV), .CNT_W(MCV_W)) mcv_tmr_i (
    .clk(clk), .rst_n(rst_n), .clr_i(mcv_clr), .run_i(mcv_run),
    .limit_i(MCV_W'(MCV_EIGHTHS)), .done_o(mcv_done)
  );

  chg_blink_gen #(.DIV(EIGHTH_DIV)) blink_i (
    .clk(clk), .rst_n(rst_n), .blink_o(blink)
  );

  chg_led_enc led_i (
    .state_i(st_q), .mode_i(disp_mode_i), .blink_i(blink), .led_o(led)
  );

  // output decode
  always_comb begin
    case (st_q)
      ST_FAST:          phase_o = PH_FAST;
      ST_TOPOFF:        phase_o = PH_TOPOFF;
      ST_PEND, ST_DONE: phase_o = rate.trickle_en ? PH_TRICKLE : PH_OFF;
      default:          phase_o = PH_OFF;
    endcase
  end

  assign out_en_o = (st_q != ST_IDLE);
  assign dis_o    = (st_q == ST_DISCH);
  assign led1_o   = led[1];
  assign led2_o   = led[0];

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!out_en_o && !dis_o && phase_o == PH_OFF && !led1_o && !led2_o));

  // R3
  dis_no_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_o |-> (phase_o == PH_OFF));

  // R3
  dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_o && active && !cell_under_edv_i) |=> dis_o);

  // R6
  mcv_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !dcmd_fall && cell_over_max_i &&
     (st_q == ST_FAST || st_q == ST_TOPOFF || st_q == ST_DONE))
    |=> (phase_o == PH_OFF && !led1_o && !led2_o));

  // R5
  absent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ABSENT && active && !dcmd_fall && cell_over_max_i) |=> (st_q == ST_ABSENT));

  // R8
  topoff_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TOPOFF && active && !dcmd_fall && !cell_over_max_i &&
     !temp_cut_i && !safe_done) |=> (st_q == ST_TOPOFF));

endmodule

// File: tb/chg_cycle_ctrl_tb_top.sv
module chg_cycle_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EDIV = 4;

  logic clk = 1'b0;
  logic rst_n, supply, inh_n, dcmd_n, omax, uedv, tcut, tcold, thot, slope;
  logic [1:0] ra, rb, dmode, vmode;
  logic out_en, dis, led1, led2;
  logic [1:0] phase;
  logic [5:0] obs;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  chg_cycle_ctrl #(.EIGHTH_DIV(EDIV), .MIN_EIGHTHS(2), .MCV_EIGHTHS(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply), .inhibit_n_i(inh_n),
    .dis_cmd_n_i(dcmd_n), .cell_over_max_i(omax), .cell_under_edv_i(uedv),
    .temp_cut_i(tcut), .temp_cold_i(tcold), .temp_hot_i(thot), .term_slope_i(slope),
    .rate_a_i(ra), .rate_b_i(rb), .disp_mode_i(dmode), .vterm_mode_i(vmode),
    .out_en_o(out_en), .dis_o(dis), .phase_o(phase), .led1_o(led1), .led2_o(led2)
  );

  // obs = {out_en, dis, phase[1:0], led1, led2}
  assign obs = {out_en, dis, phase, led1, led2};

  localparam logic [5:0] O_IDLE  = 6'b000000;
  localparam logic [5:0] O_PEND1 = 6'b101111;
  localparam logic [5:0] O_FAST1 = 6'b100101;
  localparam logic [5:0] O_DONE1 = 6'b101110;
  localparam logic [5:0] O_TOP1  = 6'b101010;
  localparam logic [5:0] O_DIS1  = 6'b110011;
  localparam logic [5:0] O_NONE  = 6'b100000;

  // {omax, uedv, hot, cold, vmode[1:0], exp_phase[1:0], exp_leds[1:0]}
  localparam int NQ = 8;
  localparam logic [9:0] QVEC [NQ] = '{
    10'b0_0_0_0_01_01_01, 10'b0_1_0_0_01_11_11, 10'b0_0_1_0_01_11_11,
    10'b0_0_0_1_01_11_11, 10'b0_0_0_1_10_01_01, 10'b0_0_0_1_00_11_11,
    10'b1_0_0_0_01_00_00, 10'b1_1_0_0_01_00_00
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [5:0] exp);
    n_chk++;
    if (obs !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, obs, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic go_fast(input string tag);
    inh_n = 1'b0; step(1);
    inh_n = 1'b1; step(2);
    chk(tag, (dmode == 2'b01) ? 6'b100100 : O_FAST1);
  endtask

  initial begin
    rst_n = 1'b0; supply = 1'b1; inh_n = 1'b1; dcmd_n = 1'b1;
    omax = 1'b0; uedv = 1'b0; tcut = 1'b0; tcold = 1'b0; thot = 1'b0; slope = 1'b0;
    ra = 2'b10; rb = 2'b00; dmode = 2'b00; vmode = 2'b01;
    step(3);
    chk("R1 reset state", O_IDLE);
    rst_n = 1'b1; step(1);
    chk("R2 start into qualification, R9 trickle", O_PEND1);

    // R4 / R5 qualification table
    for (int i = 0; i < NQ; i++) begin
      inh_n = 1'b0; omax = 0; uedv = 0; thot = 0; tcold = 0; vmode = 2'b01; step(1);
      inh_n = 1'b1; step(1);
      {omax, uedv, thot, tcold, vmode} = QVEC[i][9:4];
      step(1);
      chk($sformatf("R4 R5 qualification vector %0d", i), {1'b1, 1'b0, QVEC[i][3:0]});
    end
    omax = 0; uedv = 0; thot = 0; tcold = 0; vmode = 2'b01;
    inh_n = 1'b0; step(1);
    chk("R1 inhibit low", O_IDLE);

    // R7 slope termination without top-off
    go_fast("R4 fast entry");
    slope = 1; step(1); slope = 0;
    chk("R7 slope ends fast into complete", O_DONE1);

    // R3 discharge
    dcmd_n = 0; step(1);
    chk("R3 discharge on falling command", O_DIS1);
    step(3);
    chk("R3 discharge held above end-of-discharge", O_DIS1);
    uedv = 1; step(1);
    chk("R3 discharge ends into qualification", O_PEND1);
    uedv = 0; dcmd_n = 1; step(1);
    chk("R4 qualified after discharge", O_FAST1);

    // R6 short and long maximum-voltage episodes
    omax = 1; step(1);
    chk("R6 over max cuts charge and LEDs", O_NONE);
    step(4); omax = 0; step(1);
    chk("R6 quick fall gives complete", O_DONE1);
    omax = 1; step(20);
    chk("R6 persisting over max", O_NONE);
    omax = 0; step(1);
    chk("R5 insertion from absent restarts cycle", O_PEND1);
    step(1);

    // R7 cold flag depends on voltage mode
    tcold = 1; step(1); tcold = 0;
    chk("R7 cold ends fast", O_DONE1);
    vmode = 2'b10;
    go_fast("R7 fast entry peak mode");
    tcold = 1; step(3);
    chk("R7 cold ignored in peak mode", O_FAST1);
    tcold = 0; tcut = 1; step(1); tcut = 0;
    chk("R7 cutoff ends fast", O_DONE1);
    vmode = 2'b01;

    // R1 supply loss, R2 start with command held low
    go_fast("R2 fast entry");
    supply = 0; step(1);
    chk("R1 supply loss idles", O_IDLE);
    dcmd_n = 0; supply = 1; step(1);
    chk("R2 held command starts with discharge", O_DIS1);
    uedv = 1; step(1); uedv = 0; dcmd_n = 1;

    // R8 safety timer, 23 min no top-off (184 clocks)
    inh_n = 0; ra = 2'b01; rb = 2'b01;
    go_fast("R8 fast entry FF");
    step(179);
    chk("R8 fast before time-out", O_FAST1);
    step(10);
    chk("R8 time-out ends fast", O_DONE1);

    // R8 top-off with restart
    inh_n = 0; ra = 2'b10; rb = 2'b10;
    go_fast("R8 fast entry HH");
    step(100);
    slope = 1; step(1);
    chk("R7 slope ends fast into top-off", O_TOP1);
    tcold = 1; step(3);
    chk("R8 slope and cold ignored in top-off", O_TOP1);
    slope = 0; tcold = 0; step(150);
    chk("R8 timer restarted for top-off", O_TOP1);
    step(40);
    chk("R8 top-off time-out", O_DONE1);
    go_fast("R8 fast entry cut test");
    slope = 1; step(1); slope = 0;
    tcut = 1; step(1); tcut = 0;
    chk("R8 cutoff ends top-off", O_DONE1);

    // R12 trickle disabled
    inh_n = 0; ra = 2'b00; rb = 2'b00; step(1);
    inh_n = 1; uedv = 1; step(1);
    chk("R12 qualification without trickle", 6'b100011);
    uedv = 0; step(1);
    slope = 1; step(1); slope = 0;
    chk("R12 complete without trickle", 6'b100010);

    // R10 floating-code display mode
    inh_n = 0; dmode = 2'b01; ra = 2'b10; rb = 2'b10; step(1);
    inh_n = 1; uedv = 1; step(1);
    chk("R10 mode2 qualification", 6'b101110);
    uedv = 0; step(1);
    chk("R10 mode2 fast", 6'b100100);
    slope = 1; step(1); slope = 0;
    chk("R10 mode2 top-off", 6'b101011);
    dcmd_n = 0; step(1);
    chk("R10 mode2 discharge", 6'b110001);
    dcmd_n = 1;

    // R11 blinking display mode
    inh_n = 0; dmode = 2'b10; step(1);
    inh_n = 1; uedv = 1; step(1);
    begin
      int tog = 0;
      int l1 = 0;
      logic prev = led2;
      for (int k = 0; k < 40; k++) begin
        step(1);
        if (led2 !== prev) tog++;
        if (led1 !== 1'b0) l1++;
        prev = led2;
      end
      chk_rng("R11 blink toggles in 40 clocks", tog, 9, 11);
      chk_rng("R11 led1 low while blinking", l1, 0, 0);
    end
    uedv = 0; step(1);
    chk("R11 mode3 fast", O_FAST1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule